// File: doc/BRIEF.md
# Arbitrary-Modulus Numerically Controlled Oscillator

This block is a digital sine oscillator whose phase accumulator wraps at a programmable integer modulus instead of at a power of two. Each enabled clock cycle the accumulator adds a frequency step and, if the sum reaches the modulus, subtracts the modulus. The output frequency is therefore exactly fclk times step divided by modulus. With a modulus of one million and a step of 100, a 10 MHz clock yields exactly 1 kHz. A binary accumulator can only come near such a ratio. The sample stream is open loop and fully deterministic, so every sample, spurs included, can be predicted from the settings and the cycle count.

The phase is scaled into a table address by multiplying it with a software-supplied factor scale = floor(2^(ADDR_W+SCALE_SHIFT)/modulus), so no divider is needed. A quarter-wave table covers one quadrant, and the full cycle is rebuilt by folding. The signed sample goes to an external converter bus together with a wrap pulse and the raw phase. All three outputs pass through the same three-stage pipeline: accumulate, scale-multiply, table read.

A small controller with three states governs the accumulator. IDLE is entered at reset. It holds the phase at zero and copies the settings every cycle. The transition IDLE to RUN is taken when enable is high. RUN advances the phase each cycle. The transition RUN to HOLD is taken when enable drops. HOLD freezes the phase and the settings. The transition HOLD to RUN is taken when enable returns. Only reset leads back to IDLE.

Top module: `rational_nco`

## Requirements
- R1: While rst_n is low, and at the first sample after it, phase_o, sample_o and wrap_o are all zero. An asynchronous reset in the middle of a run also returns all three to zero.
- R2: In RUN each cycle the phase becomes phase+step, minus modulus when that sum is at least modulus. With modulus 10 and step 3 the output phase sequence is 3, 6, 9, 2. The phase is always below the active modulus.
- R3: wrap_o is high for one sample exactly when that sample's phase came from a subtraction. With modulus 1,000,000 and step 100, successive wrap pulses are exactly 10,000 cycles apart, and the phase on each wrap is 0.
- R4: With modulus 2^20 and step 105, the k-th wrap follows the k-th advance count ceil(k*2^20/105). The pulse spacing alternates between 9986 and 9987 cycles and is never 10,000. On wrap k the phase is that count times 105 minus k*2^20.
- R5: modulus, step and scale are captured in IDLE and afterwards only on a wrap cycle. A change made between wraps takes effect at the next wrap. The wrapped remainder is kept, or restarts at 0 if it is not below the new modulus.
- R6: When enable is low after leaving IDLE, the phase is frozen and no wrap is produced. Setting changes made while frozen are not captured. When enable returns, stepping continues from the frozen phase under the old settings.
- R7: The table address is bits [SCALE_SHIFT+ADDR_W-1 : SCALE_SHIFT] of phase*scale (bits 31 to 24 by default).
- R8: Let address a have quadrant a[7:6] and index a[5:0]. Quadrants 1 and 3 use index 63-a[5:0]. Quadrants 2 and 3 negate the sample. The entry for index k is floor(16*2047*i*(256-i)/(5*65536-4*i*(256-i))) with i=2k+1.
- R9: The first advance after enable reaches the outputs so that the first non-zero phase is seen on the fourth rising edge after enable is raised. phase_o, wrap_o and sample_o always describe the same accumulator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| modulus_i | input | PHASE_W (24) | Accumulator wrap modulus |
| step_i | input | PHASE_W (24) | Phase increment per cycle |
| scale_i | input | SCALE_W (32) | Phase-to-address scale factor |
| sample_o | output | SAMPLE_W (12) | Signed sine sample |
| wrap_o | output | 1 | Wrap pulse aligned with sample_o |
| phase_o | output | PHASE_W (24) | Accumulator phase aligned with sample_o |

## Verification
The assertions assume that the modulus is at least 2, that the step lies strictly between 0 and the modulus, and that scale is no larger than floor(2^32/modulus). Under those limits the phase-below-modulus and wrap-remainder properties cannot fail on a correct design. The directed scenarios only load settings that meet these limits, including the values switched in mid-run and during a hold. Setting inputs are driven on falling edges and are valid before reset is released.

// File: rtl/rnco_pkg.sv
`timescale 1ns/1ps
package rnco_pkg;

    typedef enum logic [1:0] {
        NCO_IDLE = 2'd0,
        NCO_RUN  = 2'd1,
        NCO_HOLD = 2'd2
    } nco_state_e;

    // Quarter-wave magnitude at half-sample offset, rational sine approximation.
    function automatic longint quarter_amp(input int k, input int quarter_len, input int amp);
        longint n2;
        longint i2;
        longint num;
        longint den;
        n2  = 4 * longint'(quarter_len);
        i2  = 2 * longint'(k) + 1;
        num = 16 * longint'(amp) * i2 * (n2 - i2);
        den = 5 * n2 * n2 - 4 * i2 * (n2 - i2);
        return num / den;
    endfunction

endpackage

// File: rtl/rnco_accum.sv
`timescale 1ns/1ps
module rnco_accum
    import rnco_pkg::*;
#(
    parameter int PHASE_W = 24,
    parameter int SCALE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] modulus_i,
    input  logic [PHASE_W-1:0] step_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               wrap_o,
    output logic [SCALE_W-1:0] scale_o
);

    nco_state_e state_q, state_d;

    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] mod_act_q;
    logic [PHASE_W-1:0] step_act_q;
    logic [SCALE_W-1:0] scale_act_q;
    logic               wrap_q;

    logic               advance;
    logic               load_cfg;
    logic [PHASE_W:0]   sum_w;
    logic               over_w;
    logic [PHASE_W-1:0] rem_w;
    logic [PHASE_W-1:0] next_w;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NCO_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NCO_IDLE: if (en_i)  state_d = NCO_RUN;
            NCO_RUN:  if (!en_i) state_d = NCO_HOLD;
            NCO_HOLD: if (en_i)  state_d = NCO_RUN;
            default:             state_d = NCO_IDLE;
        endcase
    end

    // Output decode: advance and capture strobes
    always_comb begin
        sum_w    = {1'b0, acc_q} + {1'b0, step_act_q};
        over_w   = (sum_w >= {1'b0, mod_act_q});
        rem_w    = over_w ? PHASE_W'(sum_w - {1'b0, mod_act_q}) : sum_w[PHASE_W-1:0];
        advance  = 1'b0;
        load_cfg = 1'b0;
        unique case (state_q)
            NCO_IDLE: load_cfg = 1'b1;
            NCO_RUN, NCO_HOLD: begin
                advance  = en_i;
                load_cfg = en_i && over_w;
            end
            default: ;
        endcase
        next_w = (advance && load_cfg && (rem_w >= modulus_i)) ? '0 : rem_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q       <= '0;
            wrap_q      <= 1'b0;
            mod_act_q   <= '1;
            step_act_q  <= '0;
            scale_act_q <= '0;
        end else begin
            if (advance) acc_q <= next_w;
            wrap_q <= advance && over_w;
            if (load_cfg) begin
                mod_act_q   <= modulus_i;
                step_act_q  <= step_i;
                scale_act_q <= scale_i;
            end
        end
    end

    assign phase_o = acc_q;
    assign wrap_o  = wrap_q;
    assign scale_o = scale_act_q;

    assert_phase_below_mod_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < mod_act_q);

    assert_wrap_remainder_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> ((acc_q == '0) || (acc_q < $past(step_act_q))));

    assert_cfg_only_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) != NCO_IDLE) && !wrap_q) |->
            ($stable(mod_act_q) && $stable(step_act_q) && $stable(scale_act_q)));

    assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != NCO_IDLE) && !en_i) |=> ($stable(acc_q) && !wrap_q));

endmodule

// File: rtl/rnco_phase_map.sv
`timescale 1ns/1ps
module rnco_phase_map #(
    parameter int PHASE_W     = 24,
    parameter int SCALE_W     = 32,
    parameter int ADDR_W      = 8,
    parameter int SCALE_SHIFT = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               wrap_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               wrap_o
);

    localparam int PROD_W = PHASE_W + SCALE_W;

    logic [PROD_W-1:0] prod_w;
    logic [ADDR_W-1:0] addr_w;

    assign prod_w = PROD_W'(phase_i) * PROD_W'(scale_i);
    assign addr_w = ADDR_W'(prod_w >> SCALE_SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o  <= '0;
            phase_o <= '0;
            wrap_o  <= 1'b0;
        end else begin
            addr_o  <= addr_w;
            phase_o <= phase_i;
            wrap_o  <= wrap_i;
        end
    end

endmodule

// File: rtl/rnco_wave_rom.sv
`timescale 1ns/1ps
module rnco_wave_rom
    import rnco_pkg::*;
#(
    parameter int PHASE_W  = 24,
    parameter int ADDR_W   = 8,
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [PHASE_W-1:0]         phase_i,
    input  logic                       wrap_i,
    output logic signed [SAMPLE_W-1:0] sample_o,
    output logic [PHASE_W-1:0]         phase_o,
    output logic                       wrap_o
);

    localparam int QUAD_W = ADDR_W - 2;
    localparam int QLEN   = 1 << QUAD_W;
    localparam int AMP    = (1 << (SAMPLE_W - 1)) - 1;

    logic signed [SAMPLE_W-1:0] qtab [QLEN];

    for (genvar k = 0; k < QLEN; k++) begin : g_qtab
        assign qtab[k] = SAMPLE_W'(quarter_amp(k, QLEN, AMP));
    end

    logic [1:0]                 quad_w;
    logic [QUAD_W-1:0]          idx_w;
    logic signed [SAMPLE_W-1:0] mag_w;

    always_comb begin
        quad_w = addr_i[ADDR_W-1 -: 2];
        idx_w  = quad_w[0] ? ~addr_i[QUAD_W-1:0] : addr_i[QUAD_W-1:0];
        mag_w  = qtab[idx_w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_o <= '0;
            phase_o  <= '0;
            wrap_o   <= 1'b0;
        end else begin
            sample_o <= quad_w[1] ? -mag_w : mag_w;
            phase_o  <= phase_i;
            wrap_o   <= wrap_i;
        end
    end

    assert_lower_half_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_i[ADDR_W-1]) |-> (sample_o <= 0));

    assert_upper_half_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(addr_i[ADDR_W-1]) |-> (sample_o >= 0));

endmodule

// File: rtl/rational_nco.sv
`timescale 1ns/1ps
module rational_nco #(
    parameter int PHASE_W     = 24,
    parameter int SCALE_W     = 32,
    parameter int ADDR_W      = 8,
    parameter int SCALE_SHIFT = 24,
    parameter int SAMPLE_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic [PHASE_W-1:0]         modulus_i,
    input  logic [PHASE_W-1:0]         step_i,
    input  logic [SCALE_W-1:0]         scale_i,
    output logic signed [SAMPLE_W-1:0] sample_o,
    output logic                       wrap_o,
    output logic [PHASE_W-1:0]         phase_o
);

    logic [PHASE_W-1:0] acc_phase;
    logic               acc_wrap;
    logic [SCALE_W-1:0] acc_scale;
    logic [ADDR_W-1:0]  map_addr;
    logic [PHASE_W-1:0] map_phase;
    logic               map_wrap;

    rnco_accum #(
        .PHASE_W (PHASE_W),
        .SCALE_W (SCALE_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .modulus_i (modulus_i),
        .step_i    (step_i),
        .scale_i   (scale_i),
        .phase_o   (acc_phase),
        .wrap_o    (acc_wrap),
        .scale_o   (acc_scale)
    );

    rnco_phase_map #(
        .PHASE_W     (PHASE_W),
        .SCALE_W     (SCALE_W),
        .ADDR_W      (ADDR_W),
        .SCALE_SHIFT (SCALE_SHIFT)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (acc_phase),
        .wrap_i  (acc_wrap),
        .scale_i (acc_scale),
        .addr_o  (map_addr),
        .phase_o (map_phase),
        .wrap_o  (map_wrap)
    );

    rnco_wave_rom #(
        .PHASE_W  (PHASE_W),
        .ADDR_W   (ADDR_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_rom (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (map_addr),
        .phase_i  (map_phase),
        .wrap_i   (map_wrap),
        .sample_o (sample_o),
        .phase_o  (phase_o),
        .wrap_o   (wrap_o)
    );

endmodule

// File: tb/rational_nco_bench.sv
`timescale 1ns/1ps
module rational_nco_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic [23:0]        modulus = 24'd10;
    logic [23:0]        stp = 24'd3;
    logic [31:0]        scale = 32'd0;
    logic signed [11:0] smp;
    logic               wrp;
    logic [23:0]        ph;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rational_nco u_rational_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .modulus_i (modulus),
        .step_i    (stp),
        .scale_i   (scale),
        .sample_o  (smp),
        .wrap_o    (wrp),
        .phase_o   (ph)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int ref_sample(longint p, longint sc);
        longint a;
        longint n2;
        longint i2;
        longint v;
        int quad;
        int idx;
        a    = ((p * sc) >> 24) & 255;
        quad = int'(a >> 6);
        idx  = int'(a & 63);
        if (quad[0]) idx = 63 - idx;
        i2 = 2 * longint'(idx) + 1;
        n2 = 256;
        v  = (16 * 2047 * i2 * (n2 - i2)) / (5 * n2 * n2 - 4 * i2 * (n2 - i2));
        if (quad[1]) v = -v;
        return int'(v);
    endfunction

    task automatic do_reset(input logic [23:0] m, input logic [23:0] s, input logic [31:0] sc);
        @(negedge clk);
        en      = 1'b0;
        rst_n   = 1'b0;
        modulus = m;
        stp     = s;
        scale   = sc;
        cyc();
        cyc();
        rst_n = 1'b1;
    endtask

    // Wait until the phase output leaves zero; returns edges waited
    task automatic wait_nonzero(output int edges);
        edges = 0;
        for (int i = 0; i < 12; i++) begin
            cyc();
            edges++;
            if (ph != 0) break;
        end
    endtask

    task automatic test_reset_r1();
        do_reset(24'd10, 24'd3, 32'd0);
        chk(ph == 0,  "R1", "phase after reset",  ph, 0);
        chk(smp == 0, "R1", "sample after reset", smp, 0);
        chk(wrp == 0, "R1", "wrap after reset",   wrp, 0);
    endtask

    task automatic test_latency_r9();
        int edges;
        do_reset(24'd10, 24'd3, 32'd0);
        en = 1'b1;
        wait_nonzero(edges);
        chk(edges == 4, "R9", "edges to first phase", edges, 4);
        chk(ph == 3, "R9", "first phase value", ph, 3);
    endtask

    // Mid-run setting change: stream compared from the first non-zero phase
    task automatic test_change_r5();
        int edges;
        int exp_p[11] = '{3, 6, 9, 2, 4, 6, 1, 3, 5, 0, 2};
        bit exp_w[11] = '{0, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0};
        do_reset(24'd10, 24'd3, 32'd0);
        en = 1'b1;
        cyc();
        modulus = 24'd7;
        stp     = 24'd2;
        wait_nonzero(edges);
        for (int i = 0; i < 11; i++) begin
            chk(ph == exp_p[i], (i < 3) ? "R2" : "R5", "phase in stream", ph, exp_p[i]);
            chk(wrp == exp_w[i], "R3", "wrap in stream", wrp, exp_w[i]);
            cyc();
        end
    endtask

    // Remainder not below new modulus restarts at zero
    task automatic test_restart_r5();
        int edges;
        int exp_p[8] = '{9, 0, 1, 2, 3, 4, 0, 1};
        bit exp_w[8] = '{0, 1, 0, 0, 0, 0, 1, 0};
        do_reset(24'd10, 24'd9, 32'd0);
        en = 1'b1;
        cyc();
        modulus = 24'd5;
        stp     = 24'd1;
        wait_nonzero(edges);
        for (int i = 0; i < 8; i++) begin
            chk(ph == exp_p[i], "R5", "restart phase", ph, exp_p[i]);
            chk(wrp == exp_w[i], "R5", "restart wrap", wrp, exp_w[i]);
            cyc();
        end
    endtask

    task automatic test_hold_r6();
        int edges;
        longint p;
        do_reset(24'd10, 24'd3, 32'd0);
        en = 1'b1;
        wait_nonzero(edges);
        cyc();
        en      = 1'b0;
        modulus = 24'd7;
        for (int i = 0; i < 5; i++) cyc();
        p = ph;
        for (int i = 0; i < 6; i++) begin
            chk(ph == p,  "R6", "phase frozen", ph, p);
            chk(wrp == 0, "R6", "no wrap when frozen", wrp, 0);
            cyc();
        end
        en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cyc();
            if (ph != p) break;
        end
        chk(ph == (p + 3) % 10, "R6", "resume step", ph, (p + 3) % 10);
        cyc();
        chk(ph == (p + 6) % 10, "R6", "resume keeps old modulus", ph, (p + 6) % 10);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(ph == 0 && wrp == 0 && smp == 0, "R1", "async reset mid-run", ph, 0);
        cyc();
        rst_n = 1'b1;
    endtask

    task automatic test_sweep_r8();
        int edges;
        int e;
        do_reset(24'd1024, 24'd4, 32'd4194304);
        en = 1'b1;
        wait_nonzero(edges);
        for (int i = 0; i < 300; i++) begin
            e = ref_sample(ph, 4194304);
            chk(int'(smp) == e, "R8", "folded sample", smp, e);
            cyc();
        end
    endtask

    // Wrap spacing for a running accumulator; returns ok status via checks
    task automatic wait_wrap(output bit seen, output int gap);
        seen = 1'b0;
        gap  = 0;
        for (int i = 0; i < 20000; i++) begin
            cyc();
            gap++;
            if (wrp) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic test_exact_r3();
        bit seen;
        int gap;
        int e;
        do_reset(24'd1000000, 24'd100, 32'd4294);
        en = 1'b1;
        wait_wrap(seen, gap);
        chk(seen, "R3", "first wrap seen", seen, 1);
        for (int k = 0; k < 3; k++) begin
            wait_wrap(seen, gap);
            chk(gap == 10000, "R3", "wrap spacing exact", gap, 10000);
            chk(ph == 0, "R3", "phase on wrap", ph, 0);
        end
        for (int i = 0; i < 40; i++) begin
            cyc();
            e = ref_sample(ph, 4294);
            chk(int'(smp) == e, "R7", "scaled address sample", smp, e);
        end
    endtask

    task automatic test_pow2_r4();
        bit seen;
        int gap;
        longint m;
        longint nk;
        longint nprev;
        m = 64'd1048576;
        do_reset(24'd1048576, 24'd105, 32'd4096);
        en = 1'b1;
        wait_wrap(seen, gap);
        chk(seen, "R4", "first wrap seen", seen, 1);
        nprev = (m + 104) / 105;
        chk(ph == nprev * 105 - m, "R4", "phase on wrap 1", ph, nprev * 105 - m);
        for (int k = 2; k <= 4; k++) begin
            nk = (k * m + 104) / 105;
            wait_wrap(seen, gap);
            chk(gap == nk - nprev, "R4", "binary wrap spacing", gap, nk - nprev);
            chk(gap != 10000, "R4", "binary spacing misses target", gap, 10000);
            chk(ph == nk * 105 - k * m, "R4", "phase on wrap", ph, nk * 105 - k * m);
            nprev = nk;
        end
    endtask

    initial begin
        test_reset_r1();
        test_latency_r9();
        test_change_r5();
        test_restart_r5();
        test_hold_r6();
        test_sweep_r8();
        test_exact_r3();
        test_pow2_r4();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(190000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule